// File: doc/BRIEF.md
# Branch and Effective Address Generator

This block computes addresses for a processor whose instruction stream is made of 16-bit words. It holds the program counter. On each accepted instruction it works out the next program counter, in one of two ways. The first is a fall-through step of one instruction word (two bytes). The second is a branch to a target that lies a signed number of words away from the fall-through point. Conditional branches carry a narrow 9-bit offset. The single unconditional jump carries a wider 10-bit offset.

In parallel, the block forms a data address. It adds a small unsigned immediate to a base register value. The immediate is not scaled.

Opcode decoding happens upstream. The mode, condition select, flags and offset fields arrive already extracted. The next program counter is registered. The taken indication and the data address are combinational views of the current inputs.

Top module: `flow_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_q` loads the parameter `START_PC` (default 16'h0100) on that edge.
- R2: When `in_valid` is low, `pc_q` keeps its value across the edge and `taken` is 0, whatever the other inputs are.
- R3: Mode encodings are 0 = sequential, 1 = conditional branch, 2 = unconditional jump, 3 = indexed data access. In modes 0 and 3 with `in_valid` high, `taken` is 0 and `pc_q` becomes `pc_q + 2` on the next edge.
- R4: In mode 1 with the condition met, `taken` is 1 and `pc_q` becomes `pc_q + 2 + (sext(rel_offs[8:0]) << 1)`. Bit 9 of `rel_offs` has no effect in this mode.
- R5: The condition uses `cond_sel`. When `cond_sel` = 0 (carry clear), it is met when `flag_c` = 0. When `cond_sel` = 1 (equal), it is met when `flag_z` = 1.
- R6: In mode 1 with the condition not met, `taken` is 0 and `pc_q` becomes `pc_q + 2`.
- R7: In mode 2, `taken` is 1 regardless of flags and `cond_sel`, and `pc_q` becomes `pc_q + 2 + (sext(rel_offs[9:0]) << 1)`.
- R8: `data_addr` always equals `base_val + zext(idx_offs)`. The 5-bit offset has range 0 to 31, is not scaled, and is combinational in every mode.
- R9: All address arithmetic wraps modulo 2^16. This covers the program counter step, branch targets and `data_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Current instruction fields are valid |
| mode | input | 2 | 0 sequential, 1 conditional branch, 2 jump, 3 indexed access |
| cond_sel | input | 1 | 0 carry clear, 1 equal |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| rel_offs | input | 10 | Signed word offset; low 9 bits used by conditional branches |
| base_val | input | 16 | Base register value for indexed access |
| idx_offs | input | 5 | Unsigned byte offset for indexed access |
| pc_q | output | 16 | Registered program counter |
| taken | output | 1 | Branch taken for the current valid input |
| data_addr | output | 16 | Indexed data address |

## Verification
Two functions can fall in the same cycle: the branch decision and the data-address sum. Both are combinational on every valid input. The vector table therefore drives a base register and an immediate alongside every branch, jump and sequential step. In that same cycle it judges `taken` and `data_addr` against hand-computed values. After the edge it judges the program-counter delta. Some vectors place wrap cases in both paths at once, so that a carry-out mistake in either sum shows up independently of the other.

// File: rtl/flow_addr_pkg.sv
package flow_addr_pkg;

    typedef enum logic [1:0] {
        FM_SEQ   = 2'd0,
        FM_BCOND = 2'd1,
        FM_JUMP  = 2'd2,
        FM_INDEX = 2'd3
    } flow_mode_e;

    typedef enum logic {
        CS_CARRY_CLR = 1'b0,
        CS_EQUAL     = 1'b1
    } cond_sel_e;

    typedef struct packed {
        logic c;
        logic z;
    } flags_t;

    typedef struct packed {
        logic       taken;
        logic       use_long;
    } branch_ctl_t;

endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
    import flow_addr_pkg::*;
(
    input  cond_sel_e sel,
    input  flags_t    flags,
    output logic      met
);

    always_comb begin
        unique case (sel)
            CS_CARRY_CLR: met = ~flags.c;
            CS_EQUAL:     met = flags.z;
            default:      met = 1'b0;
        endcase
    end

    // R5: carry set never satisfies carry-clear, zero clear never satisfies equal
    always_comb begin
        assert_cond_flags_R5: assert (!((sel == CS_CARRY_CLR && flags.c) || (sel == CS_EQUAL && !flags.z)) || !met);
    end

endmodule

// File: rtl/flow_branch_calc.sv
module flow_branch_calc #(
    parameter int AW    = 16,
    parameter int REL_S = 9,
    parameter int REL_L = 10
) (
    input  logic [AW-1:0]    pc,
    input  logic [REL_L-1:0] offs,
    input  logic             use_long,
    output logic [AW-1:0]    seq_pc,
    output logic [AW-1:0]    target
);

    localparam int EXT_S = AW - REL_S;
    localparam int EXT_L = AW - REL_L;

    logic [AW-1:0] short_words;
    logic [AW-1:0] long_words;
    logic [AW-1:0] sel_words;

    assign short_words = {{EXT_S{offs[REL_S-1]}}, offs[REL_S-1:0]};
    assign long_words  = {{EXT_L{offs[REL_L-1]}}, offs};
    assign sel_words   = use_long ? long_words : short_words;
    assign seq_pc      = pc + AW'(2);
    assign target      = seq_pc + {sel_words[AW-2:0], 1'b0};

    // R4/R7: target is even distance from sequential address
    always_comb begin
        assert_target_even_R4: assert (target[0] == pc[0]);
    end

endmodule

// File: rtl/flow_index_calc.sv
module flow_index_calc #(
    parameter int AW    = 16,
    parameter int IDX_W = 5
) (
    input  logic [AW-1:0]    base,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    addr
);

    assign addr = base + {{(AW-IDX_W){1'b0}}, idx};

    // R8: distance from base never exceeds the unscaled immediate range
    always_comb begin
        assert_index_range_R8: assert (AW'(addr - base) < AW'(1 << IDX_W));
    end

endmodule

// File: rtl/flow_addr_gen.sv
module flow_addr_gen
    import flow_addr_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          REL_S    = 9,
    parameter int          REL_L    = 10,
    parameter int          IDX_W    = 5,
    parameter logic [15:0] START_PC = 16'h0100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       mode,
    input  logic             cond_sel,
    input  logic             flag_c,
    input  logic             flag_z,
    input  logic [REL_L-1:0] rel_offs,
    input  logic [AW-1:0]    base_val,
    input  logic [IDX_W-1:0] idx_offs,
    output logic [AW-1:0]    pc_q,
    output logic             taken,
    output logic [AW-1:0]    data_addr
);

    flow_mode_e  mode_e;
    flags_t      flags;
    branch_ctl_t ctl;
    logic        cond_met;
    logic [AW-1:0] seq_pc;
    logic [AW-1:0] target;
    logic [AW-1:0] pc_d;

    assign mode_e = flow_mode_e'(mode);
    assign flags  = '{c: flag_c, z: flag_z};

    flow_cond_eval u_cond (
        .sel   (cond_sel_e'(cond_sel)),
        .flags (flags),
        .met   (cond_met)
    );

    always_comb begin
        ctl.use_long = (mode_e == FM_JUMP);
        ctl.taken    = 1'b0;
        if (in_valid) begin
            unique case (mode_e)
                FM_BCOND: ctl.taken = cond_met;
                FM_JUMP:  ctl.taken = 1'b1;
                default:  ctl.taken = 1'b0;
            endcase
        end
    end

    flow_branch_calc #(.AW(AW), .REL_S(REL_S), .REL_L(REL_L)) u_branch (
        .pc       (pc_q),
        .offs     (rel_offs),
        .use_long (ctl.use_long),
        .seq_pc   (seq_pc),
        .target   (target)
    );

    flow_index_calc #(.AW(AW), .IDX_W(IDX_W)) u_index (
        .base (base_val),
        .idx  (idx_offs),
        .addr (data_addr)
    );

    always_comb begin
        if (!in_valid)      pc_d = pc_q;
        else if (ctl.taken) pc_d = target;
        else                pc_d = seq_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= AW'(START_PC);
        else     pc_q <= pc_d;
    end

    assign taken = ctl.taken;

    assert_reset_load_R1: assert property (@(posedge clk)
        $past(rst) |-> pc_q == AW'(START_PC));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(pc_q));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !taken);

    assert_fallthru_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !taken) |=> pc_q == AW'($past(pc_q) + AW'(2)));

    assert_jump_taken_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'd2) |-> taken);

    assert_seq_no_take_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 || mode == 2'd3) |-> !taken);

endmodule

// File: tb/flow_addr_gen_tb_top.sv
module flow_addr_gen_tb_top;

    typedef struct packed {
        logic [1:0]  mode;
        logic        csel;
        logic        c;
        logic        z;
        logic [9:0]  offs;
        logic [15:0] base;
        logic [4:0]  idx;
        logic        exp_tk;
        logic [15:0] exp_delta;
        logic [15:0] exp_da;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 10'h3FF, 16'h1000, 5'd5,  1'b0, 16'h0002, 16'h1005},
        '{2'd1, 1'b0, 1'b0, 1'b0, 10'h004, 16'h2000, 5'd31, 1'b1, 16'h000A, 16'h201F},
        '{2'd1, 1'b0, 1'b1, 1'b0, 10'h004, 16'h0000, 5'd0,  1'b0, 16'h0002, 16'h0000},
        '{2'd1, 1'b1, 1'b0, 1'b1, 10'h3FF, 16'hFFF0, 5'd31, 1'b1, 16'h0000, 16'h000F},
        '{2'd1, 1'b1, 1'b1, 1'b0, 10'h100, 16'h0042, 5'd1,  1'b0, 16'h0002, 16'h0043},
        '{2'd1, 1'b0, 1'b0, 1'b1, 10'h2FF, 16'h0100, 5'd2,  1'b1, 16'h0200, 16'h0102},
        '{2'd2, 1'b0, 1'b1, 1'b0, 10'h200, 16'h1234, 5'd16, 1'b1, 16'hFC02, 16'h1244},
        '{2'd2, 1'b1, 1'b0, 1'b0, 10'h1FF, 16'h0000, 5'd1,  1'b1, 16'h0400, 16'h0001},
        '{2'd3, 1'b0, 1'b0, 1'b1, 10'h3FF, 16'hABCD, 5'd19, 1'b0, 16'h0002, 16'hABE0},
        '{2'd1, 1'b1, 1'b1, 1'b1, 10'h100, 16'hFFFF, 5'd1,  1'b1, 16'hFE02, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        cond_sel = 1'b0;
    logic        flag_c = 1'b0;
    logic        flag_z = 1'b0;
    logic [9:0]  rel_offs = '0;
    logic [15:0] base_val = '0;
    logic [4:0]  idx_offs = '0;
    logic [15:0] pc_q;
    logic        taken;
    logic [15:0] data_addr;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    flow_addr_gen dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .cond_sel(cond_sel), .flag_c(flag_c), .flag_z(flag_z),
        .rel_offs(rel_offs), .base_val(base_val), .idx_offs(idx_offs),
        .pc_q(pc_q), .taken(taken), .data_addr(data_addr)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic cs, input logic c, input logic z,
                         input logic [9:0] o, input logic [15:0] b, input logic [4:0] ix);
        @(negedge clk);
        in_valid = 1'b1; mode = m; cond_sel = cs; flag_c = c; flag_z = z;
        rel_offs = o; base_val = b; idx_offs = ix;
    endtask

    initial begin
        logic [15:0] pc_before;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset pc", pc_q, 16'h0100);
        rst = 1'b0;

        // R2: invalid input, jump mode with nonzero offset must do nothing
        @(negedge clk);
        in_valid = 1'b0; mode = 2'd2; rel_offs = 10'h055;
        #2 check("R2 idle taken", {15'd0, taken}, 16'd0);
        @(posedge clk); #2;
        check("R2 idle hold", pc_q, 16'h0100);

        // R9: wrap of pc via two jumps
        drive(2'd2, 1'b0, 1'b0, 1'b0, 10'h200, 16'h0, 5'd0);
        @(posedge clk); #2;
        check("R7 jump back", pc_q, 16'hFD02);
        drive(2'd2, 1'b0, 1'b0, 1'b0, 10'd382, 16'h0, 5'd0);
        @(posedge clk); #2;
        check("R9 pc wrap to zero", pc_q, 16'h0000);
        drive(2'd2, 1'b0, 1'b0, 1'b0, 10'h3FE, 16'h0, 5'd0);
        @(posedge clk); #2;
        check("R9 pc wrap below zero", pc_q, 16'hFFFE);
        drive(2'd0, 1'b0, 1'b0, 1'b0, 10'h0, 16'h0, 5'd0);
        @(posedge clk); #2;
        check("R9 seq step wrap", pc_q, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].mode, VECS[i].csel, VECS[i].c, VECS[i].z,
                  VECS[i].offs, VECS[i].base, VECS[i].idx);
            pc_before = pc_q;
            #2;
            check($sformatf("R5 R7 taken vec%0d", i), {15'd0, taken}, {15'd0, VECS[i].exp_tk});
            check($sformatf("R8 R9 data_addr vec%0d", i), data_addr, VECS[i].exp_da);
            @(posedge clk); #2;
            check($sformatf("R3 R4 R6 pc delta vec%0d", i), 16'(pc_q - pc_before), VECS[i].exp_delta);
        end

        // R1: reset mid-run with a valid jump present
        drive(2'd2, 1'b0, 1'b0, 1'b0, 10'h010, 16'h0, 5'd0);
        rst = 1'b1;
        @(posedge clk); #2;
        check("R1 reset overrides jump", pc_q, 16'h0100);
        rst = 1'b0;
        in_valid = 1'b0;
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (2000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule